// File: doc/BRIEF.md
# Repeating ADC Channel Sequencer

This block is the digital control side of a multichannel serial ADC. A host frames each transfer by pulling `frameN` low and giving 16 serial clocks. During those clocks the block shifts in a 16-bit control word and shifts out a 16-bit result word. A control word is taken into the configuration register only when its write-enable bit is set. The configuration holds a mask of eight analog channel enables, a temperature-channel enable and a repeat flag.

Each frame starts one conversion on the falling edge of `frameN`. In repeat mode the block steps through the enabled channels in ascending order, puts the temperature channel after the highest analog channel and then wraps around. In single mode it converts the lowest enabled channel on every frame. Any accepted write restarts the sequence. The analog converter is replaced by a stub that returns a fixed code for each channel. A result comes back one frame after its conversion starts, tagged with its channel address. When no result is pending, the word is an all-ones invalid marker.

All inputs are sampled with the system clock, which must run well above the serial clock rate.

Top module: `adc_repeat_sequencer`

## Requirements
- R1: A frame is one low period of `frameN`. Control bits are shifted in MSB first, sampled on rising edges of `serClk`. A control word is used only when the frame held exactly 16 rising edges. A frame with any other count changes no configuration, but it still starts a conversion.
- R2: Control word fields: bit 15 is write-enable, bit 14 is repeat, bit 13 enables the temperature channel, and bits 7:0 enable analog channels 7..0 (bit i is channel i). Bits 12:8 are ignored. A word with bit 15 = 0 leaves the configuration unchanged.
- R3: With repeat set, conversions move through the enabled channels in ascending index order, starting at the lowest. After the highest enabled channel they wrap back to the lowest.
- R4: When the temperature channel is enabled in repeat mode, it is converted after the highest enabled analog channel in every pass.
- R5: An accepted write restarts the sequence even when the channel selection did not change. The first conversion after the write is on the lowest enabled channel.
- R6: The result of the conversion started in frame N is shifted out during frame N+1.
- R7: A result word is {address[3:0], code[11:0]}. The address is 0..7 for analog channels and 8 for the temperature channel, and the code is 12'h0A0 + 12'h111 × address. It is shifted out MSB first. The MSB is valid after `frameN` falls, and each later bit appears after a falling edge of `serClk`. `serOut` is 0 while `frameN` is high.
- R8: The frame right after an accepted write returns the invalid word 16'hFFFF.
- R9: With no analog channel and no temperature channel enabled, no conversion starts, and the following frame returns 16'hFFFF.
- R10: With repeat clear, every frame converts the lowest enabled channel. If only the temperature channel is enabled, that channel is converted.
- R11: A synchronous reset clears the configuration, the sequence position and the pending result. The first frame after reset returns 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| frameN | input | 1 | Active-low frame select |
| serClk | input | 1 | Serial clock |
| serIn | input | 1 | Serial control data in |
| serOut | output | 1 | Serial result data out |

## Verification
The bench counts latency in frames, not in clock edges. The word read back in a frame is compared with the conversion the requirements place in the previous frame. The invalid marker is expected exactly one frame after each accepted write or reset. On the serial line, each input is registered once, and an edge is detected one clock after that. Each result bit therefore settles within three system clocks of its `serClk` falling edge. The bench samples `serOut` six clocks after that edge, just before the next rising edge. Each bench task runs its own sequence of frames and checks every returned word against the expected sequence of channel addresses.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic frameStart;  // frame select fell
    logic frameEnd;    // frame select rose
    logic shiftOut;    // serial clock fell inside a frame
    logic loadCfg;     // accepted control write at frame end
  } seqStrobe_t;

  localparam int ADDR_W = 4;

endpackage

// File: rtl/adc_seq_frame_ctrl.sv
module adc_seq_frame_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 8,
  parameter int WR_BIT = 15,
  parameter int RPT_BIT = 14,
  parameter int TMP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameN,
  input  logic              serClk,
  input  logic              serIn,
  output seqStrobe_t        strb,
  output logic              frameLow,
  output logic              cfgRepeat,
  output logic              cfgTemp,
  output logic [NUM_CH-1:0] cfgMask
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic csQ, csQ2, clkQ, clkQ2, dinQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] inWord;
  logic csFall, csRise, sckRise, sckFall;

  always_ff @(posedge clk) begin
    if (rst) begin
      csQ   <= 1'b1;
      csQ2  <= 1'b1;
      clkQ  <= 1'b0;
      clkQ2 <= 1'b0;
      dinQ  <= 1'b0;
    end else begin
      csQ   <= frameN;
      csQ2  <= csQ;
      clkQ  <= serClk;
      clkQ2 <= clkQ;
      dinQ  <= serIn;
    end
  end

  assign csFall  = csQ2 & ~csQ;
  assign csRise  = ~csQ2 & csQ;
  assign sckRise = ~clkQ2 & clkQ & ~csQ;
  assign sckFall = clkQ2 & ~clkQ & ~csQ;
  assign frameLow = ~csQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      inWord <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      inWord <= {inWord[WORD_W-2:0], dinQ};
      if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.frameStart = csFall;
    strb.frameEnd   = csRise;
    strb.shiftOut   = sckFall;
    strb.loadCfg    = csRise && (bitCnt == CNT_FULL) && inWord[WR_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgRepeat <= 1'b0;
      cfgTemp   <= 1'b0;
      cfgMask   <= '0;
    end else if (strb.loadCfg) begin
      cfgRepeat <= inWord[RPT_BIT];
      cfgTemp   <= inWord[TMP_BIT];
      cfgMask   <= inWord[NUM_CH-1:0];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.loadCfg |=> $stable({cfgRepeat, cfgTemp, cfgMask})); // R2

  AST_LOAD_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    sckRise |=> !strb.loadCfg); // R1

endmodule

// File: rtl/adc_seq_picker.sv
module adc_seq_picker #(
  parameter int NSLOT = 9,
  parameter int IDX_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] slotEn,
  input  logic [IDX_W-1:0] lastIdx,
  output logic [IDX_W-1:0] lowIdx,
  output logic [IDX_W-1:0] nextIdx,
  output logic             anyEn
);

  always_comb begin
    lowIdx = '0;
    anyEn  = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slotEn[i]) begin
        lowIdx = IDX_W'(i);
        anyEn  = 1'b1;
      end
    end
  end

  // rotating search: smallest step forward from lastIdx wins
  always_comb begin
    nextIdx = lowIdx;
    for (int k = NSLOT; k >= 1; k--) begin
      if (slotEn[(int'(lastIdx) + k) % NSLOT])
        nextIdx = IDX_W'((int'(lastIdx) + k) % NSLOT);
    end
  end

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 8,
  parameter logic [WORD_W-ADDR_W-1:0] CODE_BASE = 12'h0A0,
  parameter logic [WORD_W-ADDR_W-1:0] CODE_STEP = 12'h111
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic              cfgRepeat,
  input  logic              cfgTemp,
  input  logic [NUM_CH-1:0] cfgMask,
  output logic              doutBit
);

  localparam int NSLOT = NUM_CH + 1;
  localparam int IDX_W = $clog2(NSLOT);
  localparam int RES_W = WORD_W - ADDR_W;

  logic [NSLOT-1:0]  slotEn;
  logic [IDX_W-1:0]  lastIdx, lowIdx, nextIdx, convIdx, pendIdx;
  logic              anyEn, restartSeq, pendValid, fromStart;
  logic [WORD_W-1:0] outShift;
  logic [RES_W-1:0]  codeTab [NSLOT];

  assign slotEn = {cfgTemp, cfgMask};

  // conversion stub: one fixed code per slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_stub
    assign codeTab[g] = RES_W'(CODE_BASE + CODE_STEP * RES_W'(g));
  end

  adc_seq_picker #(.NSLOT(NSLOT), .IDX_W(IDX_W)) picker_i (
    .slotEn (slotEn),
    .lastIdx(lastIdx),
    .lowIdx (lowIdx),
    .nextIdx(nextIdx),
    .anyEn  (anyEn)
  );

  assign fromStart = restartSeq | ~cfgRepeat;
  assign convIdx   = fromStart ? lowIdx : nextIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastIdx    <= '0;
      restartSeq <= 1'b1;
      pendValid  <= 1'b0;
      pendIdx    <= '0;
      outShift   <= '1;
    end else if (strb.frameStart) begin
      outShift  <= pendValid ? {ADDR_W'(pendIdx), codeTab[pendIdx]} : '1;
      pendValid <= anyEn;
      pendIdx   <= convIdx;
      if (anyEn) begin
        lastIdx    <= convIdx;
        restartSeq <= 1'b0;
      end
    end else if (strb.loadCfg) begin
      restartSeq <= 1'b1;
      pendValid  <= 1'b0;
    end else if (strb.shiftOut) begin
      outShift <= {outShift[WORD_W-2:0], 1'b1};
    end
  end

  assign doutBit = outShift[WORD_W-1];

  AST_WRITE_VOIDS_PEND: assert property (@(posedge clk) disable iff (rst)
    strb.loadCfg |=> !pendValid); // R8

  AST_EMPTY_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    (strb.frameStart && slotEn == '0) |=> !pendValid); // R9

  AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (strb.frameStart && anyEn) |=> slotEn[lastIdx]); // R3

  AST_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (strb.frameStart && cfgRepeat && !restartSeq && $countones(slotEn) > 1)
      |=> (lastIdx > $past(lastIdx)) || (lastIdx == lowIdx)); // R3

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
    (strb.frameStart && restartSeq && anyEn) |=> (lastIdx == lowIdx)); // R5

endmodule

// File: rtl/adc_repeat_sequencer.sv
module adc_repeat_sequencer
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frameN,
  input  logic serClk,
  input  logic serIn,
  output logic serOut
);

  seqStrobe_t        strb;
  logic              frameLow, cfgRepeat, cfgTemp, doutBit;
  logic [NUM_CH-1:0] cfgMask;

  adc_seq_frame_ctrl #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .frameN   (frameN),
    .serClk   (serClk),
    .serIn    (serIn),
    .strb     (strb),
    .frameLow (frameLow),
    .cfgRepeat(cfgRepeat),
    .cfgTemp  (cfgTemp),
    .cfgMask  (cfgMask)
  );

  adc_seq_datapath #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .cfgRepeat(cfgRepeat),
    .cfgTemp  (cfgTemp),
    .cfgMask  (cfgMask),
    .doutBit  (doutBit)
  );

  assign serOut = (frameN | ~frameLow) ? 1'b0 : doutBit;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    frameN |-> !serOut); // R7

endmodule

// File: tb/adc_repeat_sequencer_tb_top.sv
module adc_repeat_sequencer_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameN = 1'b1;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic serOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  localparam logic [15:0] IDLE = 16'h7FFF;  // write-enable clear
  localparam logic [15:0] INV  = 16'hFFFF;

  always #2 clk = ~clk;

  adc_repeat_sequencer dut_i (
    .clk(clk), .rst(rst), .frameN(frameN),
    .serClk(serClk), .serIn(serIn), .serOut(serOut)
  );

  function automatic logic [15:0] expWord(input int addr);
    logic [11:0] code;
    code = 12'h0A0 + 12'h111 * 12'(addr);
    return {4'(addr), code};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic [15:0] w, input int nClk, output logic [15:0] got);
    got = '0;
    frameN = 1'b0;
    waitClk(6);
    for (int i = 0; i < nClk; i++) begin
      serIn = w[15-i];
      waitClk(6);
      got[15-i] = serOut;
      serClk = 1'b1;
      waitClk(6);
      serClk = 1'b0;
    end
    waitClk(6);
    frameN = 1'b1;
    serIn = 1'b0;
    waitClk(8);
  endtask

  task automatic expFrame(input string req, input logic [15:0] w, input logic [15:0] exp);
    logic [15:0] got;
    runFrame(w, 16, got);
    chk(req, got, exp);
  endtask

  task automatic doReset();
    rst = 1'b1;
    waitClk(4);
    rst = 1'b0;
    waitClk(4);
  endtask

  task automatic testReset();
    doReset();
    chk("R7 idle line", {15'd0, serOut}, 16'h0000);
    expFrame("R11 first frame after reset", IDLE, INV);
    expFrame("R11 config cleared", IDLE, INV);
  endtask

  task automatic testRepeat();
    logic [15:0] got;
    runFrame(16'hC007, 16, got);
    expFrame("R8 invalid after write", IDLE, INV);
    expFrame("R6 ch0 one frame later", IDLE, expWord(0));
    expFrame("R3 ascending ch1", IDLE, expWord(1));
    expFrame("R3 ascending ch2", IDLE, expWord(2));
    expFrame("R3 wrap to ch0", IDLE, expWord(0));
  endtask

  task automatic testRestart();
    expFrame("R6 pending ch1 in write frame", 16'hC007, expWord(1));
    expFrame("R8 invalid after same write", IDLE, INV);
    expFrame("R5 restart at lowest", IDLE, expWord(0));
  endtask

  task automatic testTemp();
    logic [15:0] got;
    runFrame(16'hE00A, 16, got);
    expFrame("R8 invalid after temp write", IDLE, INV);
    expFrame("R4 ch1 first", IDLE, expWord(1));
    expFrame("R4 ch3 next", IDLE, expWord(3));
    expFrame("R4 temp after last analog", IDLE, expWord(8));
    expFrame("R4 wrap to ch1", IDLE, expWord(1));
  endtask

  task automatic testSingle();
    logic [15:0] got;
    runFrame(16'h8030, 16, got);
    expFrame("R8 invalid after single write", IDLE, INV);
    expFrame("R10 lowest ch4", IDLE, expWord(4));
    expFrame("R10 ch4 again", IDLE, expWord(4));
    expFrame("R10 ch4 pending in write frame", 16'hA000, expWord(4));
    expFrame("R8 invalid after temp-only write", IDLE, INV);
    expFrame("R10 temp only", IDLE, expWord(8));
    expFrame("R10 temp only again", IDLE, expWord(8));
  endtask

  task automatic testShort();
    logic [15:0] got;
    runFrame(16'hC003, 16, got);
    expFrame("R8 invalid after write", IDLE, INV);
    expFrame("R3 ch0", IDLE, expWord(0));
    runFrame(16'h8010, 10, got);
    expFrame("R1 short write ignored", IDLE, expWord(0));
    expFrame("R1 sequence kept", IDLE, expWord(1));
  endtask

  task automatic testEmpty();
    logic [15:0] got;
    runFrame(16'hDF00, 16, got);
    expFrame("R9 empty first", IDLE, INV);
    expFrame("R9 empty again", IDLE, INV);
    expFrame("R2 bits 12:8 ignored", IDLE, INV);
  endtask

  task automatic testMidReset();
    logic [15:0] got;
    runFrame(16'hC007, 16, got);
    runFrame(IDLE, 16, got);
    runFrame(IDLE, 16, got);
    chk("R6 ch0 before reset", got, expWord(0));
    doReset();
    expFrame("R11 pending cleared", IDLE, INV);
    expFrame("R11 config cleared", IDLE, INV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    testReset();
    testRepeat();
    testRestart();
    testTemp();
    testSingle();
    testShort();
    testEmpty();
    testMidReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule